// File: doc/BRIEF.md
# Serial Memory Page-Write Receiver

This block is the write-side front end of a 512 x 8 serial memory sitting on a two-wire bus. It watches the sampled clock and data lines, recognises bus start and stop events, shifts in a command byte and a word-address byte, and answers each accepted byte with an acknowledge by pulling the data line low. After the address it collects from one to sixteen data bytes into a page-sized holding buffer and keeps a per-slot written mask, so that only the touched bytes are later programmed.

When the master ends the burst with a stop event, the block hands a 5-bit page number and the 16-bit written mask to the programming sequencer with a one-cycle `commit` pulse. The sequencer reads the held bytes through a small read port. While programming is in progress the sequencer raises `busy`. The receiver then refuses its command byte, so a master can poll for completion by repeating the command until it is acknowledged.

The controller is one state machine with eight states. `ST_IDLE` waits for a start. `ST_CMD` shifts the command byte and then moves to `ST_CMD_ACK` on accept or to `ST_SKIP` on refusal. `ST_CMD_ACK` moves to `ST_ADDR`, which shifts the address byte and then moves to `ST_ADDR_ACK`. `ST_ADDR_ACK` moves to `ST_DATA`, which shifts a data byte and then moves to `ST_DATA_ACK`. `ST_DATA_ACK` returns to `ST_DATA`. `ST_SKIP` ignores the bus. From any state, a start event goes to `ST_CMD` and a stop event goes to `ST_IDLE`. Each byte-to-acknowledge transition happens on the SCL falling edge after the eighth bit. Each acknowledge-to-next transition happens on the falling edge of the ninth clock.

Top module: `ee_pgwr_rx`

## Requirements
- R1: After reset, `sda_oe` and `commit` are low and `commit_mask` is all zero.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point restarts the command phase. A stop at any point returns the block to idle.
- R3: The command byte is accepted only when its bits [7:4] equal 4'b1010 and bit 0 (direction) is 0. Otherwise it is not acknowledged, and every following byte is ignored (not acknowledged, not stored) until the next start.
- R4: For an accepted byte, `sda_oe` goes high after the falling SCL edge of the eighth bit and stays high through the ninth clock. It drops after the falling edge of the ninth clock. `sda_oe` is low whenever SCL is high during a data bit.
- R5: The address byte of an accepted command is always acknowledged. The page number is {command bit 1, address bits [7:4]}. The first data byte is stored at buffer slot address[3:0].
- R6: After each data byte is acknowledged, only the low four address bits advance. A burst running past slot 15 wraps to slot 0 of the same page.
- R7: A data byte that lands on an already-written slot (a 17th or later byte) replaces that slot's content, and the slot's mask bit stays set.
- R8: A stop that follows at least one data byte produces exactly one single-cycle `commit` pulse, with `commit_page` and `commit_mask` describing the burst. A stop before any data byte produces no pulse.
- R9: The written mask is cleared when a new address byte is received. A repeated start in the middle of a burst abandons it without a commit.
- R10: While `busy` is high, an otherwise valid command byte is not acknowledged.
- R11: `rd_data` shows the byte held in buffer slot `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line |
| busy | input | 1 | Programming cycle in progress |
| sda_oe | output | 1 | Pull the data line low (acknowledge) |
| commit | output | 1 | One-cycle pulse: burst ready to program |
| commit_page | output | 5 | Page number of the burst (address bits 8..4) |
| commit_mask | output | 16 | Slots written in the burst |
| rd_idx | input | 4 | Buffer slot select for the sequencer |
| rd_data | output | 8 | Byte held in the selected slot |

## Verification
The burst logic is tried with several patterns. A single byte in the middle of a page pins down the slot and page mapping. A four-byte burst that starts at slot 14 separates a low-nibble wrap from a carry into the page bits. A seventeen-byte burst shows overwrite with the mask held full. A sixteen-byte burst from slot 0 marks the exact boundary. Refused commands are tried three ways: wrong type, read direction and `busy`. Each must show no acknowledge on any later byte and no commit. A stop right after the address and a repeated start in the middle of a burst separate "burst ended" from "burst abandoned". Byte contents are read back through the slot port after every commit.

// File: rtl/ee_pgwr_pkg.sv
package ee_pgwr_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_CMD_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;

endpackage

// File: rtl/ee_pgwr_sync.sv
module ee_pgwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Idle bus level is high on both lines.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '1;
                end else begin
                    if (s == 0) stage_q[s] <= d;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/ee_pgwr_buf.sv
module ee_pgwr_buf #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DEPTH-1:0]  mask
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  mask_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[i]  <= '0;
                    mask_q[i] <= 1'b0;
                end else if (clr) begin
                    mask_q[i] <= 1'b0;
                end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                    mem_q[i]  <= wr_data;
                    mask_q[i] <= 1'b1;
                end
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_idx];
    assign mask    = mask_q;

endmodule

// File: rtl/ee_pgwr_rx.sv
module ee_pgwr_rx
    import ee_pgwr_pkg::*;
#(
    parameter int          PAGE_BYTES = 16,
    parameter int          ADDR_W     = 9,
    parameter logic [3:0]  DEV_TYPE   = 4'b1010,
    parameter int          SYNC_STAGES = 2,
    localparam int         IDX_W      = $clog2(PAGE_BYTES),
    localparam int         PAGE_W     = ADDR_W - IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic                  busy,
    output logic                  sda_oe,
    output logic                  commit,
    output logic [PAGE_W-1:0]     commit_page,
    output logic [PAGE_BYTES-1:0] commit_mask,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [BYTE_W-1:0]     rd_data
);

    // ---------------- line sampling and bus events ----------------
    logic [1:0] line_s;
    logic       scl_s, sda_s, scl_p, sda_p;

    ee_pgwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_in, sda_in}),
        .q     (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

    // ---------------- controller state ----------------
    rx_state_e state_q, state_d;

    logic [BIT_W-1:0]    bitcnt_q;
    logic [BYTE_W-1:0]   shreg_q;
    logic                full_q;
    logic                a8_q;
    logic [PAGE_W-1:0]   page_q;
    logic [IDX_W-1:0]    idx_q;
    logic                has_data_q;
    logic                commit_q;

    logic byte_end;
    logic cmd_ok;
    logic shifting;

    assign byte_end = full_q & scl_fall;
    assign cmd_ok   = (shreg_q[7:4] == DEV_TYPE) && !shreg_q[0] && !busy;
    assign shifting = (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                      (state_q == ST_DATA);

    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_CMD;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_CMD:      if (byte_end) state_d = cmd_ok ? ST_CMD_ACK : ST_SKIP;
                ST_CMD_ACK:  if (scl_fall) state_d = ST_ADDR;
                ST_ADDR:     if (byte_end) state_d = ST_ADDR_ACK;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_DATA;
                ST_DATA:     if (byte_end) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_d = ST_DATA;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- byte shifter, address counter ----------------
    logic wr_en, buf_clr, idx_step;
    assign wr_en    = (state_q == ST_DATA) && (state_d == ST_DATA_ACK);
    assign buf_clr  = (state_q == ST_ADDR) && (state_d == ST_ADDR_ACK);
    assign idx_step = (state_q == ST_DATA_ACK) && (state_d == ST_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            full_q   <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bitcnt_q <= '0;
            full_q   <= 1'b0;
        end else if (shifting && scl_rise && !full_q) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_s};
            bitcnt_q <= bitcnt_q + 1'b1;
            if (bitcnt_q == BIT_W'(BYTE_W-1)) full_q <= 1'b1;
        end else if (byte_end) begin
            full_q   <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a8_q       <= 1'b0;
            page_q     <= '0;
            idx_q      <= '0;
            has_data_q <= 1'b0;
            commit_q   <= 1'b0;
        end else begin
            commit_q <= stop_ev && has_data_q &&
                        ((state_q == ST_DATA) || (state_q == ST_DATA_ACK));
            if (start_ev) has_data_q <= 1'b0;
            if ((state_q == ST_CMD) && (state_d == ST_CMD_ACK)) begin
                a8_q <= shreg_q[1];
            end
            if (buf_clr) begin
                page_q     <= {a8_q, shreg_q[BYTE_W-1:IDX_W]};
                idx_q      <= shreg_q[IDX_W-1:0];
                has_data_q <= 1'b0;
            end
            if (wr_en)    has_data_q <= 1'b1;
            if (idx_step) idx_q      <= idx_q + 1'b1;
        end
    end

    // ---------------- page buffer ----------------
    ee_pgwr_buf #(.DEPTH(PAGE_BYTES), .DATA_W(BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (wr_en),
        .wr_idx  (idx_q),
        .wr_data (shreg_q),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .mask    (commit_mask)
    );

    // ---------------- outputs ----------------
    always_comb begin
        unique case (state_q)
            ST_CMD_ACK, ST_ADDR_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            default:                              sda_oe = 1'b0;
        endcase
        commit      = commit_q;
        commit_page = page_q;
    end

endmodule

// File: rtl/ee_pgwr_chk.sv
module ee_pgwr_chk #(
    parameter int PAGE_BYTES = 16,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  start_ev,
    input logic                  stop_ev,
    input logic                  sda_oe,
    input logic                  commit,
    input logic [PAGE_BYTES-1:0] commit_mask,
    input logic                  wr_en,
    input logic [IDX_W-1:0]      idx_q
);

    // R4
    ack_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    // R4
    ack_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> (!$past(scl_s) || $past(start_ev || stop_ev)));

    // R8
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R8
    commit_mask_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (commit_mask != '0));

    // R7
    slot_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> commit_mask[$past(idx_q)]);

endmodule

bind ee_pgwr_rx ee_pgwr_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_s       (scl_s),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .sda_oe      (sda_oe),
    .commit      (commit),
    .commit_mask (commit_mask),
    .wr_en       (wr_en),
    .idx_q       (idx_q)
);

// File: tb/ee_pgwr_rx_tb.sv
module ee_pgwr_rx_tb;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_d = 1'b1;
    logic        sda_d = 1'b1;
    logic        busy = 1'b0;
    logic        sda_oe;
    logic        commit;
    logic [4:0]  commit_page;
    logic [15:0] commit_mask;
    logic [3:0]  rd_idx = '0;
    logic [7:0]  rd_data;
    logic        sda_line;

    always #10 clk = ~clk;

    assign sda_line = sda_d & ~sda_oe;

    ee_pgwr_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_d),
        .sda_in      (sda_line),
        .busy        (busy),
        .sda_oe      (sda_oe),
        .commit      (commit),
        .commit_page (commit_page),
        .commit_mask (commit_mask),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [7:0]  m_buf [16];
    logic [15:0] m_mask = '0;
    logic [4:0]  m_page = '0;
    int          m_commits = 0;
    bit          commit_ok = 0;
    int          seen_commits = 0;
    logic [4:0]  cap_page;
    logic [15:0] cap_mask;
    logic [7:0]  pay [32];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // every clock: a commit pulse must be one the model allows
    always @(negedge clk) begin
        if (rst_n && commit) begin
            seen_commits++;
            cap_page = commit_page;
            cap_mask = commit_mask;
            chk(commit_ok, "R8", "unexpected commit", 1, 0);
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl_d) begin
            sda_d = 1'b1; wait_q();
            scl_d = 1'b1; wait_q();
        end
        sda_d = 1'b0; wait_q();
        scl_d = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_d = 1'b0; wait_q();
        scl_d = 1'b1; wait_q();
        sda_d = 1'b1; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        for (int i = 7; i >= 0; i--) begin
            sda_d = b[i]; wait_q();
            scl_d = 1'b1; wait_q();
            chk(sda_oe == 1'b0, "R4", "oe during data bit", int'(sda_oe), 0);
            wait_q();
            scl_d = 1'b0; wait_q();
        end
        sda_d = 1'b1; wait_q();
        scl_d = 1'b1; wait_q();
        chk(sda_oe == exp_ack, req, "ack bit", int'(sda_oe), int'(exp_ack));
        wait_q();
        scl_d = 1'b0; wait_q();
        chk(sda_oe == 1'b0, "R4", "oe released after ninth clock", int'(sda_oe), 0);
    endtask

    // One write transaction; the model decides acks and the burst result.
    task automatic write_txn(input logic [7:0] cmd, input logic [7:0] addr,
                             input int n, input bit do_stop, input string req);
        bit ok;
        int idx;
        ok = (cmd[7:4] == 4'b1010) && !cmd[0] && !busy;
        bus_start();
        send_byte(cmd, ok, ok ? req : "R3");
        send_byte(addr, ok, "R5");
        if (ok) begin
            m_mask = '0;
            m_page = {cmd[1], addr[7:4]};
        end
        idx = int'(addr[3:0]);
        for (int k = 0; k < n; k++) begin
            send_byte(pay[k], ok, ok ? "R6" : "R3");
            if (ok) begin
                m_buf[idx] = pay[k];
                m_mask[idx] = 1'b1;
                idx = (idx + 1) % 16;
            end
        end
        if (do_stop) begin
            commit_ok = ok && (n > 0);
            if (commit_ok) m_commits++;
            bus_stop();
            repeat (6) @(negedge clk);
            commit_ok = 0;
        end
    endtask

    task automatic check_commit(input string req);
        chk(seen_commits == m_commits, req, "commit count", seen_commits, m_commits);
        chk(cap_page == m_page, req, "page", int'(cap_page), int'(m_page));
        chk(cap_mask == m_mask, req, "mask", int'(cap_mask), int'(m_mask));
        for (int s = 0; s < 16; s++) begin
            if (m_mask[s]) begin
                rd_idx = 4'(s);
                @(negedge clk);
                chk(rd_data == m_buf[s], "R11", $sformatf("slot %0d data", s),
                    int'(rd_data), int'(m_buf[s]));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 16; s++) m_buf[s] = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1", "oe at reset", int'(sda_oe), 0);
        chk(commit == 1'b0, "R1", "commit at reset", int'(commit), 0);
        chk(commit_mask == '0, "R1", "mask at reset", int'(commit_mask), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5: single byte, A8 = 1, address 0x35 -> page 0x13, slot 5
        pay[0] = 8'h5A;
        write_txn(8'hA2, 8'h35, 1, 1, "R5");
        check_commit("R5");

        // R6: four bytes from slot 14 wrap to slots 0 and 1 of the same page
        pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'h33; pay[3] = 8'h44;
        write_txn(8'hA0, 8'h4E, 4, 1, "R6");
        check_commit("R6");

        // R7: seventeen bytes from slot 0, last replaces slot 0
        for (int k = 0; k < 17; k++) pay[k] = 8'(8'h80 + k);
        write_txn(8'hA0, 8'h20, 17, 1, "R7");
        check_commit("R7");
        chk(cap_mask == 16'hFFFF, "R7", "mask full", int'(cap_mask), 16'hFFFF);

        // exact sixteen bytes on the top page
        for (int k = 0; k < 16; k++) pay[k] = 8'(8'hC0 ^ k);
        write_txn(8'hA2, 8'hF0, 16, 1, "R6");
        check_commit("R6");

        // R10: busy refuses the command; nothing acked, no commit
        busy = 1'b1;
        pay[0] = 8'hEE;
        write_txn(8'hA0, 8'h10, 2, 1, "R10");
        busy = 1'b0;
        chk(seen_commits == m_commits, "R10", "no commit while busy", seen_commits, m_commits);

        // R3: wrong device type and read direction are refused
        write_txn(8'hB0, 8'h10, 2, 1, "R3");
        write_txn(8'hA1, 8'h10, 2, 1, "R3");
        chk(seen_commits == m_commits, "R3", "no commit on refused", seen_commits, m_commits);

        // R8: stop right after the address, no commit; mask cleared (R9)
        write_txn(8'hA0, 8'h63, 0, 1, "R8");
        chk(seen_commits == m_commits, "R8", "no commit without data", seen_commits, m_commits);
        chk(commit_mask == '0, "R9", "mask cleared by address", int'(commit_mask), 0);

        // R9/R2: repeated start mid burst abandons it; next burst stands alone
        pay[0] = 8'h01; pay[1] = 8'h02; pay[2] = 8'h03;
        write_txn(8'hA0, 8'h70, 3, 0, "R9");
        pay[0] = 8'h99;
        write_txn(8'hA0, 8'h7C, 1, 1, "R2");
        check_commit("R9");
        chk(cap_mask == 16'h1000, "R9", "only second burst", int'(cap_mask), 16'h1000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule